// File: doc/BRIEF.md
# Power Threshold Throttle Monitor

This block watches a measured power consumption figure, given in whole watts, and compares it with two software-programmed ceilings. Crossing the lower ceiling asks the surrounding logic for moderate (50%) throttling. Crossing the upper ceiling asks for heavy (90%) throttling. The requested level appears on a 2-bit output one clock after the inputs that caused it.

Software reaches the block through a plain 64-bit register port with a single write strobe and a read address. The port has four words:
- A status word carries the consumed power and a summary flag. The flag says whether every accelerator unit can tolerate slow memory.
- A threshold word holds both ceilings and two live alarm bits.
- Two read-only limit words report externally supplied power limits in tenths of a watt. Each limit reads as zero unless its valid bit is set.

Top module: `pwr_throttle_mon`

## Requirements
- R1: After reset, both thresholds hold 127, so the threshold word reads 0x7F7F (with no alarm bits while power is below 127) and `throttle_lvl` is 0.
- R2: A read of address 0 returns the consumed power in bits [17:0] and `lat_ok_in` in bit 18. `lat_ok_in` is 1 when every unit tolerates 40 µs or more of memory latency. All higher bits read 0.
- R3: A write to address 1 loads threshold 1 from write bits [6:0] and threshold 2 from write bits [14:8]. All other write bits are ignored.
- R4: Address 1 reads threshold 1 in [6:0] and threshold 2 in [14:8]. Bit 16 is 1 exactly when power ≥ threshold 1, and bit 17 is 1 exactly when power ≥ threshold 2. The comparison uses the full 18-bit power value, with each threshold zero-extended. Bits 7, 15 and 18 to 63 read 0.
- R5: `throttle_lvl` is 2 (90%) when power ≥ threshold 2, else 1 (50%) when power ≥ threshold 1, else 0. The value 3 never appears.
- R6: Addresses 2 and 3 return limit input A and limit input B. Bits [14:0] carry the limit in 0.1 W and bit 15 carries the valid bit. When the valid bit is 0, the whole word reads 0.
- R7: A write to address 0, 2 or 3 leaves both thresholds unchanged.
- R8: Read data is registered. `reg_rdata` shows the word selected by `reg_addr`, as computed from the inputs present at the previous rising clock edge. `throttle_lvl` has the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_in | input | 18 | Measured power consumption in watts |
| lat_ok_in | input | 1 | 1 when all accelerator units tolerate at least 40 µs memory latency |
| lim_a_in | input | 16 | Power limit A: [14:0] in 0.1 W, [15] valid |
| lim_b_in | input | 16 | Power limit B: [14:0] in 0.1 W, [15] valid |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| throttle_lvl | output | 2 | Requested throttle: 0 none, 1 50%, 2 90% |

## Verification
The bench sweeps power across every value from 0 to 140, and also large 18-bit values, under threshold pairs that are equal, ordered either way, zero and at the maximum. This exposes a strict-versus-inclusive compare, which would drop the alarm at exact equality. It also exposes a compare truncated to 7 bits, which would miss alarms for power at 128 and above. Where threshold 1 lies above threshold 2, a design in which the lower level won would report 50% when 90% is due. Write data with the reserved bits set catches thresholds that are loaded from the wrong positions or that leak those bits into read-back. Limit words with the valid bit clear but a non-zero value catch a design that forgets to gate the value.

// File: rtl/pwr_thr_pkg.sv
package pwr_thr_pkg;

   typedef enum logic [1:0] {
      THR_NONE  = 2'd0,
      THR_HALF  = 2'd1,
      THR_HEAVY = 2'd2
   } throttle_e;

   localparam int unsigned ADDR_STATUS  = 0;
   localparam int unsigned ADDR_THRESH  = 1;
   localparam int unsigned ADDR_LIMIT_A = 2;
   localparam int unsigned ADDR_LIMIT_B = 3;

   localparam int unsigned T2_LSB   = 8;
   localparam int unsigned ALM1_BIT = 16;
   localparam int unsigned ALM2_BIT = 17;

   // The upper alarm outranks the lower one.
   function automatic throttle_e pick_level(input logic alm1, input logic alm2);
      if (alm2)
         return THR_HEAVY;
      else if (alm1)
         return THR_HALF;
      else
         return THR_NONE;
   endfunction

endpackage

// File: rtl/pwr_thr_regs.sv
module pwr_thr_regs
   import pwr_thr_pkg::*;
#(
   parameter int unsigned THR_W  = 7,
   parameter int unsigned ADDR_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [T2_LSB+THR_W-1:0]    wfield,
   output logic [THR_W-1:0]           thr1,
   output logic [THR_W-1:0]           thr2
);

   localparam logic [THR_W-1:0] THR_RST = {THR_W{1'b1}};

   logic hit;
   assign hit = we && (addr == ADDR_W'(ADDR_THRESH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr1 <= THR_RST;
         thr2 <= THR_RST;
      end else if (hit) begin
         thr1 <= wfield[THR_W-1:0];
         thr2 <= wfield[T2_LSB +: THR_W];
      end
   end

endmodule

// File: rtl/pwr_thr_cmp.sv
module pwr_thr_cmp
   import pwr_thr_pkg::*;
#(
   parameter int unsigned PWR_W   = 18,
   parameter int unsigned THR_W   = 7,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PWR_W-1:0]  power,
   input  logic [THR_W-1:0]  thr1,
   input  logic [THR_W-1:0]  thr2,
   output logic              alm1,
   output logic              alm2,
   output logic [1:0]        level
);

   logic [PWR_W-1:0] thr1_x;
   logic [PWR_W-1:0] thr2_x;
   throttle_e        lvl_d;

   assign thr1_x = PWR_W'(thr1);
   assign thr2_x = PWR_W'(thr2);
   assign alm1   = (power >= thr1_x);
   assign alm2   = (power >= thr2_x);
   assign lvl_d  = pick_level(alm1, alm2);

   generate
      if (REG_OUT) begin : g_reg
         throttle_e lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lvl_q <= THR_NONE;
            else
               lvl_q <= lvl_d;
         end
         assign level = lvl_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign level = lvl_d;
      end
   endgenerate

endmodule

// File: rtl/pwr_thr_rdmux.sv
module pwr_thr_rdmux
   import pwr_thr_pkg::*;
#(
   parameter int unsigned PWR_W   = 18,
   parameter int unsigned THR_W   = 7,
   parameter int unsigned LIM_W   = 15,
   parameter int unsigned NUM_LIM = 2,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [PWR_W-1:0]              power,
   input  logic                          lat_ok,
   input  logic [THR_W-1:0]              thr1,
   input  logic [THR_W-1:0]              thr2,
   input  logic                          alm1,
   input  logic                          alm2,
   input  logic [NUM_LIM-1:0][LIM_W:0]   lim_raw,
   output logic [DATA_W-1:0]             rdata
);

   logic [DATA_W-1:0]               w_status;
   logic [DATA_W-1:0]               w_thresh;
   logic [NUM_LIM-1:0][DATA_W-1:0]  w_limit;
   logic [DATA_W-1:0]               rd_d;

   always_comb begin
      w_status             = '0;
      w_status[PWR_W-1:0]  = power;
      w_status[PWR_W]      = lat_ok;
   end

   always_comb begin
      w_thresh                  = '0;
      w_thresh[THR_W-1:0]       = thr1;
      w_thresh[T2_LSB +: THR_W] = thr2;
      w_thresh[ALM1_BIT]        = alm1;
      w_thresh[ALM2_BIT]        = alm2;
   end

   // A limit whose valid bit is clear reads as an all-zero word.
   generate
      for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
         always_comb begin
            w_limit[i] = '0;
            if (lim_raw[i][LIM_W]) begin
               w_limit[i][LIM_W-1:0] = lim_raw[i][LIM_W-1:0];
               w_limit[i][LIM_W]     = 1'b1;
            end
         end
      end
   endgenerate

   always_comb begin
      unique case (int'(addr))
         ADDR_STATUS:  rd_d = w_status;
         ADDR_THRESH:  rd_d = w_thresh;
         ADDR_LIMIT_A: rd_d = w_limit[0];
         ADDR_LIMIT_B: rd_d = w_limit[NUM_LIM-1];
         default:      rd_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else
         rdata <= rd_d;
   end

endmodule

// File: rtl/pwr_throttle_mon.sv
module pwr_throttle_mon
   import pwr_thr_pkg::*;
#(
   parameter int unsigned PWR_W   = 18,
   parameter int unsigned THR_W   = 7,
   parameter int unsigned LIM_W   = 15,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned ADDR_W  = 2,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PWR_W-1:0]  power_in,
   input  logic              lat_ok_in,
   input  logic [LIM_W:0]    lim_a_in,
   input  logic [LIM_W:0]    lim_b_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [1:0]        throttle_lvl
);

   localparam int unsigned NUM_LIM = 2;
   localparam int unsigned WF_W    = T2_LSB + THR_W;

   generate
      if (THR_W > T2_LSB) begin : g_bad_thr
         $error("THR_W must not exceed 8");
      end
      if (PWR_W < THR_W) begin : g_bad_pwr
         $error("PWR_W must be at least THR_W");
      end
      if (DATA_W < PWR_W + 1 || DATA_W <= ALM2_BIT || DATA_W <= LIM_W) begin : g_bad_data
         $error("DATA_W too narrow for the register layout");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover four words");
      end
   endgenerate

   logic [THR_W-1:0]              thr1_q;
   logic [THR_W-1:0]              thr2_q;
   logic                          alm1;
   logic                          alm2;
   logic [NUM_LIM-1:0][LIM_W:0]   lim_raw;

   assign lim_raw[0] = lim_a_in;
   assign lim_raw[1] = lim_b_in;

   pwr_thr_regs #(
      .THR_W  (THR_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wfield (reg_wdata[WF_W-1:0]),
      .thr1   (thr1_q),
      .thr2   (thr2_q)
   );

   pwr_thr_cmp #(
      .PWR_W   (PWR_W),
      .THR_W   (THR_W),
      .REG_OUT (REG_OUT)
   ) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .power (power_in),
      .thr1  (thr1_q),
      .thr2  (thr2_q),
      .alm1  (alm1),
      .alm2  (alm2),
      .level (throttle_lvl)
   );

   pwr_thr_rdmux #(
      .PWR_W   (PWR_W),
      .THR_W   (THR_W),
      .LIM_W   (LIM_W),
      .NUM_LIM (NUM_LIM),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (reg_addr),
      .power   (power_in),
      .lat_ok  (lat_ok_in),
      .thr1    (thr1_q),
      .thr2    (thr2_q),
      .alm1    (alm1),
      .alm2    (alm2),
      .lim_raw (lim_raw),
      .rdata   (reg_rdata)
   );

endmodule

// File: rtl/pwr_thr_chk.sv
module pwr_thr_chk
   import pwr_thr_pkg::*;
#(
   parameter int unsigned PWR_W   = 18,
   parameter int unsigned THR_W   = 7,
   parameter int unsigned LIM_W   = 15,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned ADDR_W  = 2,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PWR_W-1:0]  power_in,
   input  logic [LIM_W:0]    lim_a_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic [1:0]        throttle_lvl,
   input  logic [THR_W-1:0]  thr1_q,
   input  logic [THR_W-1:0]  thr2_q
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else
         armed <= 1'b1;
   end

   logic thr_wr;
   assign thr_wr = reg_we && (reg_addr == ADDR_W'(ADDR_THRESH));

   p_level_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      throttle_lvl != 2'd3);

   p_thr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(thr_wr) |->
         thr1_q == $past(reg_wdata[THR_W-1:0]) &&
         thr2_q == $past(reg_wdata[T2_LSB +: THR_W]));

   p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(thr_wr) |-> $stable(thr1_q) && $stable(thr2_q));

   p_limit_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(reg_addr == ADDR_W'(ADDR_LIMIT_A) && !lim_a_in[LIM_W]) |->
         reg_rdata == '0);

   p_status_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(reg_addr == ADDR_W'(ADDR_STATUS)) |->
         reg_rdata[DATA_W-1:PWR_W+1] == '0);

   generate
      if (REG_OUT) begin : g_seq
         p_heavy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $past(power_in >= PWR_W'(thr2_q)) |-> throttle_lvl == 2'd2);
         p_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $past(power_in >= PWR_W'(thr1_q) && power_in < PWR_W'(thr2_q)) |->
               throttle_lvl == 2'd1);
         p_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $past(power_in < PWR_W'(thr1_q) && power_in < PWR_W'(thr2_q)) |->
               throttle_lvl == 2'd0);
      end
   endgenerate

endmodule

bind pwr_throttle_mon pwr_thr_chk #(
   .PWR_W   (PWR_W),
   .THR_W   (THR_W),
   .LIM_W   (LIM_W),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .power_in     (power_in),
   .lim_a_in     (lim_a_in),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .throttle_lvl (throttle_lvl),
   .thr1_q       (thr1_q),
   .thr2_q       (thr2_q)
);

// File: tb/sim_pwr_throttle_mon.sv
module sim_pwr_throttle_mon;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [17:0] power_in = '0;
   logic        lat_ok_in = 1'b0;
   logic [15:0] lim_a_in = '0;
   logic [15:0] lim_b_in = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [1:0]  throttle_lvl;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pwr_throttle_mon u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .power_in     (power_in),
      .lat_ok_in    (lat_ok_in),
      .lim_a_in     (lim_a_in),
      .lim_b_in     (lim_b_in),
      .reg_we       (reg_we),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .throttle_lvl (throttle_lvl)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      reg_we = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      step();
      reg_we = 1'b0;
      reg_wdata = '0;
   endtask

   function automatic logic [63:0] thr_word(input int t1, input int t2, input int p);
      logic [63:0] w;
      w = '0;
      w[6:0]  = 7'(t1);
      w[14:8] = 7'(t2);
      w[16]   = (p >= t1);
      w[17]   = (p >= t2);
      return w;
   endfunction

   function automatic logic [1:0] lvl_of(input int t1, input int t2, input int p);
      if (p >= t2) return 2'd2;
      if (p >= t1) return 2'd1;
      return 2'd0;
   endfunction

   task automatic probe(input int t1, input int t2, input int p);
      power_in = 18'(p);
      reg_addr = 2'd1;
      step();
      check("R4 threshold word", reg_rdata, thr_word(t1, t2, p));
      check("R5 throttle level", 64'(throttle_lvl), 64'(lvl_of(t1, t2, p)));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int tp1[6];
      int tp2[6];
      tp1 = '{5, 10, 0, 64, 127, 127};
      tp2 = '{10, 5, 0, 64, 127, 0};

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1 throttle in reset", 64'(throttle_lvl), 64'd0);
      rst_n = 1'b1;
      reg_addr = 2'd1;
      step();
      check("R1 threshold reset word", reg_rdata, 64'h7F7F);
      check("R1 throttle after reset", 64'(throttle_lvl), 64'd0);

      // R2 / R8: status word with assorted powers and flag values
      foreach (tp1[k]) begin
         int pw;
         pw = (k == 5) ? 18'h3FFFF : (k * 4099) % 262144;
         power_in = 18'(pw);
         lat_ok_in = k[0];
         reg_addr = 2'd0;
         step();
         check("R2 status word", reg_rdata, {45'd0, k[0], 18'(pw)});
      end
      lat_ok_in = 1'b0;

      // R3: write with reserved bits set
      wr(2'd1, 64'hFFFF_FFFF_FFFF_8A85);
      probe(5, 10, 0);
      probe(5, 10, 7);

      // R7: writes to other addresses leave thresholds alone
      wr(2'd0, 64'h0000_0000_0000_0101);
      wr(2'd2, 64'h0000_0000_0000_0202);
      wr(2'd3, 64'h0000_0000_0000_0303);
      probe(5, 10, 3);

      // R4 / R5: sweep power under several threshold pairs
      foreach (tp1[k]) begin
         wr(2'd1, 64'(tp1[k]) | (64'(tp2[k]) << 8));
         for (int p = 0; p <= 140; p++) probe(tp1[k], tp2[k], p);
         probe(tp1[k], tp2[k], 131072);
         probe(tp1[k], tp2[k], 262143);
      end
      power_in = '0;

      // R6: limit words with valid set and clear
      for (int en = 0; en < 2; en++) begin
         int vals[5];
         vals = '{0, 1, 'h1234, 'h4000, 'h7FFF};
         foreach (vals[k]) begin
            logic [63:0] ea;
            logic [63:0] eb;
            lim_a_in = {en[0], 15'(vals[k])};
            lim_b_in = {~en[0], 15'(vals[k] ^ 'h7FFF)};
            ea = en[0] ? 64'({1'b1, 15'(vals[k])}) : 64'd0;
            eb = en[0] ? 64'd0 : 64'({1'b1, 15'(vals[k] ^ 'h7FFF)});
            reg_addr = 2'd2;
            step();
            check("R6 limit A", reg_rdata, ea);
            reg_addr = 2'd3;
            step();
            check("R6 limit B", reg_rdata, eb);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule